// File: doc/BRIEF.md
# Row-Buffered Non-Volatile Word Writer with SECDED

This block sequences word accesses to a row-organised non-volatile cell array. Every stored word is a 39-bit codeword: 32 data bits and 7 check bits of a Hamming code that corrects one flipped bit and detects two. A read returns the decoded word together with a "fixed" or "fail" flag. A word that cannot be corrected is returned as all ones.

A write never touches a single word in place. The sequencer first copies every word of the target row into a row buffer, then puts the new codeword into its slot. It then erases the whole row, which sets every bit to one, and after that programs the row from the buffer, which can only clear bits. Each of the two steps takes a parameterised number of clock cycles. The busy flag drops only after programming ends. If the new codeword already matches the stored one, the erase and program steps are skipped. In raw mode the host supplies the check bits itself instead of having them computed. This is how known error patterns get stored.

The array holds its contents through reset. A reset during the erase step or the program step returns the sequencer to idle and leaves the row exactly as far as the update had got.

Top module: `nvm_row_writer`

## Requirements
- R1: A codeword holds the data in bits [31:0] and the check bits in [38:32]. The data bits occupy Hamming positions 1..38 that are not powers of two, in ascending order. Check bit j (j = 0..5) is the XOR of the data bits whose position has bit j set. Check bit 6 is the even parity of the data and check bits 0..5. A word stored with correct check bits reads back unchanged, with rsp_fixed=0 and rsp_fail=0.
- R2: A stored word with exactly one flipped bit, in any of the 39 positions, reads back as the original data with rsp_fixed=1 and rsp_fail=0.
- R3: A stored word with two flipped bits, or with odd parity and a syndrome above 38, reads back as 32'hFFFFFFFF with rsp_fail=1 and rsp_fixed=0.
- R4: After reset, busy and rsp_valid are 0. A read keeps busy high for exactly one cycle, and rsp_valid pulses for one cycle in the cycle after that.
- R5: A write that changes the stored codeword keeps busy high for WORDS+1+ERASE_CYCLES+PROG_CYCLES cycles. The erase strobe comes before the program strobe, and busy falls right after programming. The word then reads back as written, and the other words of the row are unchanged.
- R6: A write whose codeword equals the stored codeword keeps busy high for only WORDS+1 cycles, and the stored word is unchanged.
- R7: With cmd_raw=1 the array stores cmd_check as the check bits instead of the computed ones.
- R8: cmd_valid is ignored while busy is high. A command presented then changes no word.
- R9: A reset during the erase step leaves the row with its old contents, and busy is 0 after reset.
- R10: A reset during the program step leaves the row erased. Every word of that row then reads as 32'hFFFFFFFF with rsp_fail=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the sequencer (array contents persist) |
| cmd_valid | input | 1 | Command request, accepted when busy is 0 |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_raw | input | 1 | 1 = store cmd_check as the check bits on a write |
| cmd_addr | input | log2(ROWS)+log2(WORDS) | Word address: row in the upper bits, word in the lower bits |
| cmd_data | input | 32 | Write data |
| cmd_check | input | 7 | Check bits used in raw mode |
| busy | output | 1 | Sequencer is not idle |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_data | output | 32 | Decoded read data |
| rsp_fixed | output | 1 | A single-bit error was corrected |
| rsp_fail | output | 1 | The word was uncorrectable |

## Verification
The hardest states to reach are the half-finished row updates: a row whose erase was cut off, and a row that was erased but never programmed. The bench tracks busy cycle by cycle and asserts reset at a cycle it has chosen inside the erase window and inside the program window. It then reads the whole row back. Error patterns cannot be injected at the array, so they are stored through raw mode. The bench computes the correct check bits itself and XORs in one or two flipped bits, covering all 39 single positions and selected double positions. Writing back a stored codeword identically exercises the skip path.

// File: rtl/nvm_rw_pkg.sv
// Shared constants, sequencer state type and Hamming helper functions
// for the row-buffered non-volatile word writer.
// Assumes a 32-bit data word protected at Hamming positions 1..38.
package nvm_rw_pkg;

    localparam int DATA_W  = 32;
    localparam int CHK_W   = 7;
    localparam int CODE_W  = DATA_W + CHK_W;
    localparam int HAM_POS = 38;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_LOAD,
        ST_MERGE,
        ST_ERASE,
        ST_PROG
    } seq_state_t;

    // XOR of the Hamming positions of all data bits that are set.
    function automatic logic [5:0] data_syndrome(input logic [DATA_W-1:0] d);
        logic [5:0] s;
        int         k;
        s = '0;
        k = 0;
        for (int pos = 1; pos <= HAM_POS; pos++) begin
            if ((pos & (pos - 1)) != 0) begin
                if (d[k[4:0]]) s ^= pos[5:0];
                k++;
            end
        end
        return s;
    endfunction

    // Data bit index stored at a non-power-of-two Hamming position.
    function automatic logic [4:0] data_index(input logic [5:0] p);
        logic [4:0] idx;
        int         k;
        idx = '0;
        k   = 0;
        for (int pos = 1; pos <= HAM_POS; pos++) begin
            if ((pos & (pos - 1)) != 0) begin
                if (pos[5:0] == p) idx = k[4:0];
                k++;
            end
        end
        return idx;
    endfunction

endpackage

// File: rtl/nvm_secded_enc.sv
// Check-bit generator: six Hamming parity bits plus one overall parity bit.
// Purely combinational; assumes the bit layout of nvm_rw_pkg.
module nvm_secded_enc
    import nvm_rw_pkg::*;
(
    input  logic [DATA_W-1:0] data_in,
    output logic [CHK_W-1:0]  check_out
);

    logic [5:0] ham;

    // Hamming parity bits and overall even parity.
    always_comb begin
        ham       = data_syndrome(data_in);
        check_out = {(^data_in) ^ (^ham), ham};
    end

endmodule

// File: rtl/nvm_secded_dec.sv
// Codeword decoder: corrects one flipped bit and flags uncorrectable words.
// An uncorrectable word is returned as all ones. Combinational.
module nvm_secded_dec
    import nvm_rw_pkg::*;
(
    input  logic [CODE_W-1:0] code_in,
    output logic [DATA_W-1:0] data_out,
    output logic              fixed,
    output logic              fail
);

    logic [5:0] syn;
    logic       par;

    // Syndrome and overall parity of the stored codeword.
    always_comb begin
        syn = data_syndrome(code_in[DATA_W-1:0]) ^ code_in[DATA_W+5:DATA_W];
        par = ^code_in;
    end

    // Classify the error and repair or poison the data.
    always_comb begin
        data_out = code_in[DATA_W-1:0];
        fixed    = 1'b0;
        fail     = 1'b0;
        if (par) begin
            if (syn == 6'd0) begin
                fixed = 1'b1;
            end else if (syn > 6'(HAM_POS)) begin
                fail = 1'b1;
            end else begin
                fixed = 1'b1;
                if ((syn & (syn - 6'd1)) != 6'd0)
                    data_out[data_index(syn)] = ~data_out[data_index(syn)];
            end
        end else if (syn != 6'd0) begin
            fail = 1'b1;
        end
        if (fail) data_out = '1;
    end

endmodule

// File: rtl/nvm_cell_array.sv
// Behavioural cell array of ROWS x WORDS codewords. A row erase sets every
// bit to one and a row program can only clear bits. Contents are not reset.
// Assumes ROWS and WORDS are powers of two, so the address is {row, word}.
module nvm_cell_array
    import nvm_rw_pkg::*;
#(
    parameter int ROWS  = 4,
    parameter int WORDS = 4,
    localparam int RW   = $clog2(ROWS),
    localparam int AW   = $clog2(ROWS) + $clog2(WORDS)
) (
    input  logic                    clk,
    input  logic [AW-1:0]           rd_addr,
    output logic [CODE_W-1:0]       rd_code,
    input  logic                    erase_en,
    input  logic                    prog_en,
    input  logic [RW-1:0]           row_sel,
    input  logic [WORDS*CODE_W-1:0] prog_row
);

    logic [CODE_W-1:0] cells [ROWS*WORDS];

    // Word read port.
    assign rd_code = cells[rd_addr];

    for (genvar gr = 0; gr < ROWS; gr++) begin : g_row
        for (genvar gw = 0; gw < WORDS; gw++) begin : g_word
            // One cell word: erase to ones, program by clearing bits.
            always_ff @(posedge clk) begin
                if (erase_en && row_sel == RW'(gr))
                    cells[gr*WORDS+gw] <= '1;
                else if (prog_en && row_sel == RW'(gr))
                    cells[gr*WORDS+gw] <= cells[gr*WORDS+gw] & prog_row[gw*CODE_W +: CODE_W];
            end
        end
    end

endmodule

// File: rtl/nvm_row_writer.sv
// Row-buffered word writer. A read decodes one word in a single cycle.
// A write loads the row into a buffer, merges the new codeword, and stops
// there if the word is unchanged. Otherwise it runs a timed row erase and a
// timed row program. Commands are taken only when idle. Reset returns the
// sequencer to idle and leaves the array as it is.
module nvm_row_writer
    import nvm_rw_pkg::*;
#(
    parameter int ROWS         = 4,
    parameter int WORDS        = 4,
    parameter int ERASE_CYCLES = 24,
    parameter int PROG_CYCLES  = 40,
    localparam int RW          = $clog2(ROWS),
    localparam int WW          = $clog2(WORDS),
    localparam int AW          = RW + WW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_write,
    input  logic              cmd_raw,
    input  logic [AW-1:0]     cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic [CHK_W-1:0]  cmd_check,
    output logic              busy,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_fixed,
    output logic              rsp_fail
);

    localparam int TMAX = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
    localparam int TW   = $clog2(TMAX + 1);

    seq_state_t        state;
    logic [AW-1:0]     tgt_addr;
    logic [CODE_W-1:0] new_code;
    logic [WW-1:0]     idx;
    logic [TW-1:0]     tmr;
    logic [CODE_W-1:0] rbuf [WORDS];

    logic [CHK_W-1:0]        enc_check;
    logic [CODE_W-1:0]       cmd_code;
    logic [AW-1:0]           rd_addr;
    logic [CODE_W-1:0]       rd_code;
    logic [DATA_W-1:0]       dec_data;
    logic                    dec_fixed;
    logic                    dec_fail;
    logic                    erase_en;
    logic                    prog_en;
    logic                    same;
    logic [RW-1:0]           tgt_row;
    logic [WW-1:0]           tgt_word;
    logic [WORDS*CODE_W-1:0] prog_row;

    nvm_secded_enc u_enc (
        .data_in   (cmd_data),
        .check_out (enc_check)
    );

    nvm_secded_dec u_dec (
        .code_in  (rd_code),
        .data_out (dec_data),
        .fixed    (dec_fixed),
        .fail     (dec_fail)
    );

    nvm_cell_array #(
        .ROWS  (ROWS),
        .WORDS (WORDS)
    ) u_array (
        .clk      (clk),
        .rd_addr  (rd_addr),
        .rd_code  (rd_code),
        .erase_en (erase_en),
        .prog_en  (prog_en),
        .row_sel  (tgt_row),
        .prog_row (prog_row)
    );

    // Address split, codeword selection and step strobes.
    always_comb begin
        tgt_row  = tgt_addr[AW-1:WW];
        tgt_word = tgt_addr[WW-1:0];
        cmd_code = cmd_raw ? {cmd_check, cmd_data} : {enc_check, cmd_data};
        rd_addr  = (state == ST_LOAD) ? {tgt_row, idx} : tgt_addr;
        erase_en = (state == ST_ERASE) && (tmr == TW'(ERASE_CYCLES - 1));
        prog_en  = (state == ST_PROG) && (tmr == TW'(PROG_CYCLES - 1));
        same     = (rbuf[tgt_word] == new_code);
        busy     = (state != ST_IDLE);
    end

    // Flatten the row buffer onto the program bus.
    for (genvar gw = 0; gw < WORDS; gw++) begin : g_pack
        assign prog_row[gw*CODE_W +: CODE_W] = rbuf[gw];
    end

    // Sequencer: accept, load, merge, erase, program.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            tgt_addr <= '0;
            new_code <= '0;
            idx      <= '0;
            tmr      <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        tgt_addr <= cmd_addr;
                        new_code <= cmd_code;
                        idx      <= '0;
                        state    <= cmd_write ? ST_LOAD : ST_READ;
                    end
                end
                ST_READ: state <= ST_IDLE;
                ST_LOAD: begin
                    idx <= idx + 1'b1;
                    if (idx == WW'(WORDS - 1)) state <= ST_MERGE;
                end
                ST_MERGE: begin
                    tmr   <= '0;
                    state <= same ? ST_IDLE : ST_ERASE;
                end
                ST_ERASE: begin
                    if (erase_en) begin
                        tmr   <= '0;
                        state <= ST_PROG;
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                ST_PROG: begin
                    if (prog_en) state <= ST_IDLE;
                    else         tmr   <= tmr + 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Row buffer: copy of the row, then the merged new word.
    always_ff @(posedge clk) begin
        if (state == ST_LOAD)
            rbuf[idx] <= rd_code;
        else if (state == ST_MERGE)
            rbuf[tgt_word] <= new_code;
    end

    // Registered read response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
            rsp_fixed <= 1'b0;
            rsp_fail  <= 1'b0;
        end else begin
            rsp_valid <= (state == ST_READ);
            if (state == ST_READ) begin
                rsp_data  <= dec_data;
                rsp_fixed <= dec_fixed;
                rsp_fail  <= dec_fail;
            end
        end
    end

endmodule

// File: rtl/nvm_row_writer_chk.sv
// Property checker for nvm_row_writer, attached by bind. It counts busy
// cycles itself to check the position of the erase and program strobes.
module nvm_row_writer_chk #(
    parameter int WORDS        = 4,
    parameter int ERASE_CYCLES = 24,
    parameter int PROG_CYCLES  = 40
) (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        erase_en,
    input logic        prog_en,
    input logic        rsp_valid,
    input logic [31:0] rsp_data,
    input logic        rsp_fixed,
    input logic        rsp_fail
);

    localparam int ERASE_AT = WORDS + ERASE_CYCLES;
    localparam int PROG_AT  = WORDS + ERASE_CYCLES + PROG_CYCLES;
    localparam int BW       = $clog2(PROG_AT + 2) + 1;

    logic [BW-1:0] bcnt;
    logic          erased_q;

    // Index of the current busy cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)    bcnt <= '0;
        else if (busy) bcnt <= bcnt + 1'b1;
        else           bcnt <= '0;
    end

    // Set by an erase strobe, cleared by a program strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)        erased_q <= 1'b0;
        else if (erase_en) erased_q <= 1'b1;
        else if (prog_en)  erased_q <= 1'b0;
    end

    p_fail_ones_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fail |-> rsp_data == 32'hFFFF_FFFF);

    p_flags_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !(rsp_fixed && rsp_fail));

    p_rsp_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_rsp_after_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(busy) && $past(bcnt) == '0);

    p_erase_time_r5: assert property (@(posedge clk) disable iff (!rst_n)
        erase_en |-> busy && bcnt == BW'(ERASE_AT));

    p_prog_time_r5: assert property (@(posedge clk) disable iff (!rst_n)
        prog_en |-> busy && bcnt == BW'(PROG_AT));

    p_prog_after_erase_r5: assert property (@(posedge clk) disable iff (!rst_n)
        prog_en |-> erased_q);

    p_busy_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(bcnt) == '0 || $past(bcnt) == BW'(WORDS) || $past(prog_en)));

endmodule

bind nvm_row_writer nvm_row_writer_chk #(
    .WORDS        (WORDS),
    .ERASE_CYCLES (ERASE_CYCLES),
    .PROG_CYCLES  (PROG_CYCLES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .erase_en  (erase_en),
    .prog_en   (prog_en),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .rsp_fixed (rsp_fixed),
    .rsp_fail  (rsp_fail)
);

// File: tb/tb_nvm_row_writer.sv
module tb_nvm_row_writer;

    localparam int ROWS = 4;
    localparam int W    = 4;
    localparam int E    = 24;
    localparam int P    = 40;
    localparam int AW   = 4;
    localparam int NW   = ROWS * W;
    localparam int LEN_FULL = W + 1 + E + P;
    localparam int LEN_SKIP = W + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_write = 1'b0;
    logic          cmd_raw = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic [31:0]   cmd_data = '0;
    logic [6:0]    cmd_check = '0;
    logic          busy;
    logic          rsp_valid;
    logic [31:0]   rsp_data;
    logic          rsp_fixed;
    logic          rsp_fail;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    bit [38:0] st_cw [NW];
    bit        known [NW];
    bit [31:0] exp_d [NW];
    bit        exp_fx [NW];
    bit        exp_fl [NW];

    always #2 clk = ~clk;

    nvm_row_writer #(
        .ROWS(ROWS), .WORDS(W), .ERASE_CYCLES(E), .PROG_CYCLES(P)
    ) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_raw(cmd_raw), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .cmd_check(cmd_check), .busy(busy), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .rsp_fixed(rsp_fixed), .rsp_fail(rsp_fail)
    );

    // Independent check-bit model built from the positional rule of R1.
    function automatic bit [6:0] tb_check(input bit [31:0] d);
        bit [6:0] c;
        int pos;
        c = '0;
        pos = 1;
        for (int i = 0; i < 32; i++) begin
            while ((pos & (pos - 1)) == 0) pos++;
            if (d[i]) c[5:0] = c[5:0] ^ pos[5:0];
            pos++;
        end
        c[6] = ^{d, c[5:0]};
        return c;
    endfunction

    function automatic bit [38:0] clean_cw(input bit [31:0] d);
        return {tb_check(d), d};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    task automatic do_cmd(input bit wr, input bit raw, input bit [AW-1:0] a,
                          input bit [31:0] d, input bit [6:0] c, output int n,
                          output bit rv, output bit [31:0] rd, output bit rfx, output bit rfl);
        @(negedge clk);
        cmd_write = wr; cmd_raw = raw; cmd_addr = a; cmd_data = d; cmd_check = c;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        n = 0;
        while (busy && n < 2000) begin
            n++;
            @(negedge clk);
        end
        rv = rsp_valid; rd = rsp_data; rfx = rsp_fixed; rfl = rsp_fail;
    endtask

    // Write a codeword (raw or computed) and record the expected read result.
    task automatic wr(input bit raw, input bit [AW-1:0] a, input bit [38:0] cw,
                      input bit [31:0] ed, input bit efx, input bit efl, input string req);
        int n; bit rv; bit [31:0] rd; bit rfx, rfl; int expn;
        expn = (known[a] && st_cw[a] == cw) ? LEN_SKIP : LEN_FULL;
        do_cmd(1'b1, raw, a, cw[31:0], cw[38:32], n, rv, rd, rfx, rfl);
        if (known[a]) chk(n == expn, req, "busy cycles of write", 64'(n), 64'(expn));
        st_cw[a] = cw; known[a] = 1'b1;
        exp_d[a] = ed; exp_fx[a] = efx; exp_fl[a] = efl;
    endtask

    task automatic rd_expect(input bit [AW-1:0] a, input string req);
        int n; bit rv; bit [31:0] rd; bit rfx, rfl;
        do_cmd(1'b0, 1'b0, a, 32'h0, 7'h0, n, rv, rd, rfx, rfl);
        chk(rv && n == 1, "R4", "read busy/rsp_valid", {31'b0, rv, 32'(n)}, {31'b0, 1'b1, 32'd1});
        chk({rd, rfx, rfl} == {exp_d[a], exp_fx[a], exp_fl[a]}, req, "read data/fixed/fail",
            64'({rd, rfx, rfl}), 64'({exp_d[a], exp_fx[a], exp_fl[a]}));
    endtask

    task automatic reset_pulse();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic start_write(input bit [AW-1:0] a, input bit [31:0] d);
        @(negedge clk);
        cmd_write = 1'b1; cmd_raw = 1'b0; cmd_addr = a; cmd_data = d; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(200000 * 4);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        int n; bit rv; bit [31:0] rd; bit rfx, rfl;
        bit [31:0] d;
        bit [38:0] cw;
        void'($urandom(32'd7311));
        for (int i = 0; i < NW; i++) known[i] = 1'b0;

        // R4: reset state.
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && rsp_valid == 1'b0, "R4", "reset outputs",
            64'({busy, rsp_valid}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R5: fill every word with a normal write, then read all back.
        for (int a = 0; a < NW; a++) begin
            d = 32'h1000_0000 + 32'(a) * 32'h0101_0101;
            wr(1'b0, AW'(a), clean_cw(d), d, 1'b0, 1'b0, "R5");
        end
        for (int a = 0; a < NW; a++) rd_expect(AW'(a), "R5");

        // R5: change one word, neighbours keep their values.
        wr(1'b0, 4'd5, clean_cw(32'hCAFE_1234), 32'hCAFE_1234, 1'b0, 1'b0, "R5");
        for (int a = 4; a < 8; a++) rd_expect(AW'(a), "R5");

        // R6: identical rewrite is skipped.
        wr(1'b0, 4'd5, clean_cw(32'hCAFE_1234), 32'hCAFE_1234, 1'b0, 1'b0, "R6");
        rd_expect(4'd5, "R6");

        // R1/R7: raw write with correct check bits reads clean.
        wr(1'b1, 4'd2, clean_cw(32'hA5A5_0F0F), 32'hA5A5_0F0F, 1'b0, 1'b0, "R7");
        rd_expect(4'd2, "R1");
        wr(1'b0, 4'd6, clean_cw(32'h0000_0001), 32'h0000_0001, 1'b0, 1'b0, "R1");
        rd_expect(4'd6, "R1");

        // R2: every single flipped bit position, stored through raw mode.
        d = 32'h5A3C_96E1;
        for (int b = 0; b < 39; b++) begin
            cw = clean_cw(d) ^ (39'd1 << b);
            wr(1'b1, 4'd3, cw, d, 1'b1, 1'b0, "R2");
            rd_expect(4'd3, "R2");
        end

        // R3: double errors and an out-of-range syndrome.
        wr(1'b1, 4'd3, clean_cw(d) ^ 39'h3, 32'hFFFF_FFFF, 1'b0, 1'b1, "R3");
        rd_expect(4'd3, "R3");
        wr(1'b1, 4'd3, clean_cw(d) ^ (39'd1 << 5) ^ (39'd1 << 33), 32'hFFFF_FFFF, 1'b0, 1'b1, "R3");
        rd_expect(4'd3, "R3");
        wr(1'b1, 4'd3, clean_cw(d) ^ (39'd1 << 31) ^ (39'd1 << 38), 32'hFFFF_FFFF, 1'b0, 1'b1, "R3");
        rd_expect(4'd3, "R3");
        wr(1'b1, 4'd3, {39{1'b1}}, 32'hFFFF_FFFF, 1'b0, 1'b1, "R3");
        rd_expect(4'd3, "R3");

        // R8: a command during busy is ignored.
        start_write(4'd12, 32'h7777_0000);
        repeat (3) @(negedge clk);
        cmd_write = 1'b1; cmd_raw = 1'b0; cmd_addr = 4'd1; cmd_data = 32'hDEAD_BEEF;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        n = 0;
        while (busy && n < 2000) begin n++; @(negedge clk); end
        st_cw[12] = clean_cw(32'h7777_0000); exp_d[12] = 32'h7777_0000;
        exp_fx[12] = 1'b0; exp_fl[12] = 1'b0;
        rd_expect(4'd1, "R8");
        rd_expect(4'd12, "R8");

        // R9: reset inside the erase window keeps the old row.
        start_write(4'd4, 32'h1111_2222);
        repeat (W + 1 + 5) @(negedge clk);
        reset_pulse();
        chk(busy == 1'b0, "R9", "busy after reset", 64'(busy), 64'd0);
        for (int a = 4; a < 8; a++) rd_expect(AW'(a), "R9");

        // R10: reset inside the program window leaves the row erased.
        start_write(4'd8, 32'h3333_4444);
        repeat (W + E + 6) @(negedge clk);
        reset_pulse();
        chk(busy == 1'b0, "R10", "busy after reset", 64'(busy), 64'd0);
        for (int a = 8; a < 12; a++) begin
            st_cw[a] = {39{1'b1}}; exp_d[a] = 32'hFFFF_FFFF;
            exp_fx[a] = 1'b0; exp_fl[a] = 1'b1;
        end
        for (int a = 8; a < 12; a++) rd_expect(AW'(a), "R10");

        // Random mix of reads, writes, identical rewrites and error patterns.
        for (int it = 0; it < 80; it++) begin
            bit [AW-1:0] a;
            int op, b1, b2;
            a  = AW'($urandom % NW);
            op = $urandom % 6;
            d  = $urandom;
            case (op)
                0: rd_expect(a, "R5");
                1: wr(1'b0, a, clean_cw(d), d, 1'b0, 1'b0, "R5");
                2: begin
                    wr(1'b1, a, st_cw[a], exp_d[a], exp_fx[a], exp_fl[a], "R6");
                    rd_expect(a, "R6");
                end
                3: begin
                    b1 = $urandom % 39;
                    wr(1'b1, a, clean_cw(d) ^ (39'd1 << b1), d, 1'b1, 1'b0, "R2");
                    rd_expect(a, "R2");
                end
                4: begin
                    b1 = $urandom % 39;
                    b2 = (b1 + 1 + ($urandom % 38)) % 39;
                    wr(1'b1, a, clean_cw(d) ^ (39'd1 << b1) ^ (39'd1 << b2),
                       32'hFFFF_FFFF, 1'b0, 1'b1, "R3");
                    rd_expect(a, "R3");
                end
                default: begin
                    wr(1'b1, a, clean_cw(d), d, 1'b0, 1'b0, "R7");
                    rd_expect(a, "R7");
                end
            endcase
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule